// File: doc/BRIEF.md
# Byte-Wide I/O Slave for a Stackable ISA-Style Bus

This block is the bus-facing front end of an add-in card on an 8-bit ISA-style stackable bus. The host is always the bus master. The block watches the address latch strobe and stores the 15-bit address when that strobe falls. It treats the card as selected only while AEN is low and the upper address bits equal a base address set by a parameter. The low four address bits pick one of sixteen byte registers that the card's back-end logic can see.

The active-low read and write strobes, the latch strobe and AEN pass through two-flop synchronizers into the core clock domain. A write is committed when the write strobe rises. At that moment the block raises a one-cycle, one-hot pulse toward the back end and stores the byte it sampled while the strobe was low. On a read, the block drives the selected register onto the outgoing data lines and raises the output enable for as long as the read strobe is low. At all other times the enable stays low and the drive value is zero, so a pad wrapper can leave the bus at high impedance.

Top module: `isa_io_slave`

## Requirements
- R1: After reset, all sixteen registers in `reg_file` are zero, `bus_data_oe` is low and `reg_wr_pulse` is zero.
- R2: A write cycle stores `bus_data_in` into the register whose index is `bus_addr[3:0]`, at the rising edge of IOW. The cycle qualifies when AEN is low, the latched `bus_addr[14:4]` equals `BASE_ADDR`, and IOR is high. Register k occupies `reg_file[8k+7:8k]`.
- R3: During a read cycle with the same qualification (AEN low, base match, IOW high, IOR low), `bus_data_oe` is high and `bus_data_out` carries the selected register.
- R4: When the latched upper address bits differ from `BASE_ADDR`, reads do not drive the bus and writes change no register.
- R5: While AEN is high, the block ignores the cycle: no drive, no pulse and no register change.
- R6: When IOR and IOW are low together, the block does nothing: the bus is not driven and the write is not committed when the strobes rise.
- R7: Each committed write gives exactly one clock cycle in which `reg_wr_pulse` has only bit k set, for target register k, and `reg_wr_data` equals the written byte in that cycle.
- R8: The address is taken when ALE falls. Later changes on `bus_addr` within the cycle do not change which register is accessed or whether the card is selected.
- R9: Whenever `bus_data_oe` is low, `bus_data_out` is zero.
- R10: Asserting reset after registers have been written clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 15 | Bus address |
| bus_aen | input | 1 | Address enable; high means the cycle is not for I/O slaves |
| bus_ale | input | 1 | Address latch strobe; address taken on its falling edge |
| bus_ior_n | input | 1 | Active-low read strobe |
| bus_iow_n | input | 1 | Active-low write strobe |
| bus_data_in | input | 8 | Data lines as seen from the bus |
| bus_data_out | output | 8 | Data to drive onto the bus during reads |
| bus_data_oe | output | 1 | Drive enable for the data lines |
| reg_wr_pulse | output | 16 | One-hot write pulse per register |
| reg_wr_data | output | 8 | Byte being written, valid with the pulse |
| reg_file | output | 128 | Flattened contents of the sixteen registers |

## Verification
The hardest cases to reach involve timing across the synchronizers. One is an address that changes after ALE has fallen. The other is IOR and IOW released in the same cycle, where a careless design would see a clean IOW rise and commit the write. The stimulus holds the address stable for several clocks after ALE falls, so that the synchronized edge sees it, and then moves `bus_addr` to a different value as the strobes rise. In a separate cycle it drops and releases both strobes in the same cycles. A behavioural model keeps a short history of the strobe samples and predicts the enable, drive value, pulse and register contents on every clock.

// File: rtl/isa_io_slave.sv
module isa_io_slave #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4,
  parameter logic [ADDR_W-SEL_W-1:0] BASE_ADDR = 'h030
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_aen,
  input  logic                         bus_ale,
  input  logic                         bus_ior_n,
  input  logic                         bus_iow_n,
  input  logic [DATA_W-1:0]            bus_data_in,
  output logic [DATA_W-1:0]            bus_data_out,
  output logic                         bus_data_oe,
  output logic [(1<<SEL_W)-1:0]        reg_wr_pulse,
  output logic [DATA_W-1:0]            reg_wr_data,
  output logic [(1<<SEL_W)*DATA_W-1:0] reg_file
);
  localparam int NREG = 1 << SEL_W;
  localparam logic [3:0] SYNC_IDLE = 4'b0111;

  logic [3:0] sync1, sync2;
  logic ale_d, iow_d, ior_d;
  logic [ADDR_W-1:0] addr_lat;
  logic addr_ok;
  logic [DATA_W-1:0] wr_hold;
  logic [DATA_W-1:0] regs [NREG];

  wire ale_s = sync2[3];
  wire aen_s = sync2[2];
  wire ior_s = sync2[1];
  wire iow_s = sync2[0];
  wire [SEL_W-1:0] idx = addr_lat[SEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= SYNC_IDLE;
      sync2 <= SYNC_IDLE;
      ale_d <= 1'b0;
      iow_d <= 1'b1;
      ior_d <= 1'b1;
    end else begin
      sync1 <= {bus_ale, bus_aen, bus_ior_n, bus_iow_n};
      sync2 <= sync1;
      ale_d <= ale_s;
      iow_d <= iow_s;
      ior_d <= ior_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_lat <= '0;
      addr_ok  <= 1'b0;
    end else if (ale_d && !ale_s) begin
      addr_lat <= bus_addr;
      addr_ok  <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wr_hold <= '0;
    else if (!iow_s) wr_hold <= bus_data_in;

  wire sel     = addr_ok && !aen_s && (addr_lat[ADDR_W-1:SEL_W] == BASE_ADDR);
  wire rd_en   = sel && !ior_s && iow_s;
  wire wr_fire = sel && iow_s && !iow_d && ior_s && ior_d;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      assign reg_wr_pulse[g] = wr_fire && (idx == SEL_W'(g));
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) regs[g] <= '0;
        else if (reg_wr_pulse[g]) regs[g] <= wr_hold;
      assign reg_file[g*DATA_W +: DATA_W] = regs[g];
    end
  endgenerate

  assign reg_wr_data  = wr_hold;
  assign bus_data_oe  = rd_en;
  assign bus_data_out = rd_en ? regs[idx] : '0;
endmodule

// File: rtl/isa_io_slave_chk.sv
module isa_io_slave_chk #(
  parameter int NREG = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_aen,
  input logic            bus_ior_n,
  input logic            bus_iow_n,
  input logic            bus_data_oe,
  input logic [NREG-1:0] reg_wr_pulse
);
  assert_onehot_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wr_pulse));

  assert_pulse_on_iow_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_wr_pulse) |-> ($past(bus_iow_n, 2) && !$past(bus_iow_n, 3)));

  assert_no_pulse_with_ior_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_wr_pulse) |-> ($past(bus_ior_n, 2) && $past(bus_ior_n, 3)));

  assert_drive_needs_ior_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> (!$past(bus_ior_n, 2) && $past(bus_iow_n, 2)));

  assert_aen_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data_oe || (|reg_wr_pulse)) |-> !$past(bus_aen, 2));

  assert_single_cycle_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_wr_pulse) |=> !(|reg_wr_pulse));
endmodule

bind isa_io_slave isa_io_slave_chk #(.NREG(1 << SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_aen(bus_aen), .bus_ior_n(bus_ior_n),
  .bus_iow_n(bus_iow_n), .bus_data_oe(bus_data_oe), .reg_wr_pulse(reg_wr_pulse)
);

// File: tb/isa_io_slave_tb.sv
module isa_io_slave_tb;
  localparam logic [10:0] BASE = 11'h030;

  logic clk = 0, rst_n = 0;
  logic [14:0] bus_addr = '0;
  logic bus_aen = 1, bus_ale = 0, bus_ior_n = 1, bus_iow_n = 1;
  logic [7:0] bus_data_in = '0;
  logic [7:0] bus_data_out;
  logic bus_data_oe;
  logic [15:0] reg_wr_pulse;
  logic [7:0] reg_wr_data;
  logic [127:0] reg_file;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  isa_io_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_aen(bus_aen),
    .bus_ale(bus_ale), .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n),
    .bus_data_in(bus_data_in), .bus_data_out(bus_data_out),
    .bus_data_oe(bus_data_oe), .reg_wr_pulse(reg_wr_pulse),
    .reg_wr_data(reg_wr_data), .reg_file(reg_file)
  );

  // behavioural reference: history of sampled strobes, newest first
  bit h_ale[3], h_aen[3], h_ior[3], h_iow[3];
  bit m_ok;
  logic [14:0] m_addr;
  logic [7:0] m_hold;
  logic [7:0] m_regs [16];

  function automatic bit m_sel();
    return m_ok && !h_aen[1] && (m_addr[14:4] == BASE);
  endfunction
  function automatic bit m_rd();
    return m_sel() && !h_ior[1] && h_iow[1];
  endfunction
  function automatic bit m_wr();
    return m_sel() && h_iow[1] && !h_iow[2] && h_ior[1] && h_ior[2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        h_ale[i] = 0; h_aen[i] = 1; h_ior[i] = 1; h_iow[i] = 1;
      end
      m_ok = 0; m_addr = '0; m_hold = '0;
      for (int i = 0; i < 16; i++) m_regs[i] = '0;
    end else begin
      if (m_wr()) m_regs[m_addr[3:0]] = m_hold;
      if (!h_iow[1]) m_hold = bus_data_in;
      if (h_ale[2] && !h_ale[1]) begin m_addr = bus_addr; m_ok = 1; end
      for (int i = 2; i > 0; i--) begin
        h_ale[i] = h_ale[i-1]; h_aen[i] = h_aen[i-1];
        h_ior[i] = h_ior[i-1]; h_iow[i] = h_iow[i-1];
      end
      h_ale[0] = bus_ale; h_aen[0] = bus_aen; h_ior[0] = bus_ior_n; h_iow[0] = bus_iow_n;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  int pulse_cnt = 0;
  logic [15:0] last_pulse;
  logic [7:0] last_wdata;

  always @(posedge clk) begin
    #4;
    if (rst_n) begin
      logic [15:0] ep;
      logic [127:0] ef;
      ep = m_wr() ? (16'h1 << m_addr[3:0]) : 16'h0;
      for (int i = 0; i < 16; i++) ef[i*8 +: 8] = m_regs[i];
      chk("R3 model oe", bus_data_oe, m_rd());
      chk("R9 model data", bus_data_out, m_rd() ? m_regs[m_addr[3:0]] : 8'h0);
      chk("R7 model pulse", reg_wr_pulse, ep);
      if (ep != 0) chk("R7 model wdata", reg_wr_data, m_hold);
      chk("R2 model regs", reg_file, ef);
      if (reg_wr_pulse != 0) begin
        pulse_cnt++; last_pulse = reg_wr_pulse; last_wdata = reg_wr_data;
      end
    end
  end

  task automatic bus_cycle(input logic [14:0] a, input bit aen, input bit wr, input bit rd,
                           input logic [7:0] d, input logic [14:0] a_late,
                           output logic [7:0] rv, output bit roe);
    @(negedge clk); bus_addr = a; bus_aen = aen; bus_ale = 1;
    @(negedge clk); bus_ale = 0;
    repeat (4) @(negedge clk);
    bus_data_in = d;
    if (wr) bus_iow_n = 0;
    if (rd) bus_ior_n = 0;
    repeat (5) @(negedge clk);
    rv = bus_data_out; roe = bus_data_oe;
    bus_iow_n = 1; bus_ior_n = 1; bus_addr = a_late;
    repeat (4) @(negedge clk);
    bus_aen = 1; bus_data_in = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] reg_of(input int k);
    return reg_file[k*8 +: 8];
  endfunction

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv; bit roe; int pc;
    repeat (3) @(negedge clk);
    chk("R1 oe after reset", bus_data_oe, 1'b0);
    chk("R1 regs after reset", reg_file, 128'h0);
    chk("R1 pulse after reset", reg_wr_pulse, 16'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    pc = pulse_cnt;
    bus_cycle(15'h303, 0, 1, 0, 8'h5A, 15'h303, rv, roe);
    chk("R2 write reg3", reg_of(3), 8'h5A);
    chk("R7 pulse count", pulse_cnt - pc, 1);
    chk("R7 pulse bit", last_pulse, 16'h0008);
    chk("R7 pulse data", last_wdata, 8'h5A);

    bus_cycle(15'h303, 0, 0, 1, 8'h00, 15'h303, rv, roe);
    chk("R3 read oe", roe, 1'b1);
    chk("R3 read data", rv, 8'h5A);

    bus_cycle(15'h30F, 0, 1, 0, 8'hC3, 15'h30F, rv, roe);
    bus_cycle(15'h300, 0, 1, 0, 8'h11, 15'h300, rv, roe);
    bus_cycle(15'h30F, 0, 0, 1, 8'h00, 15'h30F, rv, roe);
    chk("R3 read reg15", rv, 8'hC3);
    bus_cycle(15'h300, 0, 0, 1, 8'h00, 15'h300, rv, roe);
    chk("R3 read reg0", rv, 8'h11);

    pc = pulse_cnt;
    bus_cycle(15'h313, 0, 1, 0, 8'hFF, 15'h313, rv, roe);
    chk("R4 mismatch write", reg_of(3), 8'h5A);
    chk("R4 mismatch pulse", pulse_cnt - pc, 0);
    bus_cycle(15'h703, 0, 0, 1, 8'h00, 15'h703, rv, roe);
    chk("R4 mismatch read oe", roe, 1'b0);
    chk("R9 idle data", rv, 8'h00);

    bus_cycle(15'h303, 1, 1, 0, 8'hEE, 15'h303, rv, roe);
    chk("R5 aen write", reg_of(3), 8'h5A);
    bus_cycle(15'h303, 1, 0, 1, 8'h00, 15'h303, rv, roe);
    chk("R5 aen read oe", roe, 1'b0);

    pc = pulse_cnt;
    bus_cycle(15'h303, 0, 1, 1, 8'h77, 15'h303, rv, roe);
    chk("R6 both strobes oe", roe, 1'b0);
    chk("R6 both strobes reg", reg_of(3), 8'h5A);
    chk("R6 both strobes pulse", pulse_cnt - pc, 0);

    bus_cycle(15'h303, 0, 0, 1, 8'h00, 15'h123, rv, roe);
    chk("R8 late addr read", rv, 8'h5A);
    bus_cycle(15'h123, 0, 1, 0, 8'h99, 15'h303, rv, roe);
    chk("R8 late addr write", reg_of(3), 8'h5A);
    bus_cycle(15'h305, 0, 1, 0, 8'h42, 15'h000, rv, roe);
    chk("R8 latched write", reg_of(5), 8'h42);

    @(negedge clk);
    chk("R9 idle oe", bus_data_oe, 1'b0);
    chk("R9 idle out", bus_data_out, 8'h00);

    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R10 regs cleared", reg_file, 128'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule